// File: doc/BRIEF.md
# Serial Converter Readout and Power-Mode Sequencer

This block is the master end of a three-wire link to a serial-output sampling converter. The three wires are an active-low select, a serial clock and a serial data return. When a sample is requested, the block lowers select and waits a short lead time. It then runs a burst of serial clock cycles made by an integer divider, shifts in the returned bits, and raises select again. After that it holds off the next request until the converter's quiet and acquisition minimums have passed. The block only offers a new frame when both minimums are met.

The converter reads its power mode from the number of serial clock falling edges it sees before select rises. A full frame of 16 falling edges returns a result. A release after 10 to 15 edges abandons the conversion and keeps the converter powered. A release before the 10th edge puts the converter to sleep. A frame that starts while the converter sleeps wakes it, as long as that frame reaches 10 edges, but its data is of no use. The mode request is sampled once, when a frame is accepted. Each frame ends with exactly one strobe: either a valid strobe carrying the right-aligned result, or an invalid strobe.

Top module: `sadc_ctrl`

## Requirements
- R1: While reset is high and on the first cycle after it, `cs_n_o` and `sclk_o` are high, and `busy_o`, `valid_o`, `invalid_o` and `sleep_o` are low.
- R2: A request with `busy_o` low makes `cs_n_o` fall on the next clock edge. `sclk_o` stays high for LEAD_CYC + DIV_HALF cycles before its first fall. Each serial half period is then DIV_HALF cycles. `sclk_o` is high whenever `cs_n_o` is high.
- R3: With `mode_i` = 2'b00 (full), or the unused code 2'b11, a frame has exactly 16 falling edges of `sclk_o`. `cs_n_o` rises DIV_HALF cycles after the 16th rising edge.
- R4: In a full frame, the bits on rising edges 15-RES_W+1 through 15 (edge 1 is the first rise after select falls) form the result, first bit most significant. The result is right-aligned in `data_o`, and `valid_o` pulses for one cycle in the cycle `cs_n_o` rises. This holds only if `sleep_o` was low when the frame was accepted.
- R5: With `mode_i` = 2'b01 (abandon), select rises after ABORT_EDGE falling edges (10 to 15). `invalid_o` pulses, `data_o` keeps its previous value, and `sleep_o` ends low.
- R6: With `mode_i` = 2'b10 (sleep), select rises after SLEEP_EDGE falling edges (fewer than 10), `invalid_o` pulses and `sleep_o` goes high. `sleep_o` changes only in a cycle where `cs_n_o` rises.
- R7: A frame accepted while `sleep_o` is high never raises `valid_o`. It clears `sleep_o` if it reaches at least 10 falling edges, and otherwise leaves `sleep_o` high.
- R8: Between the rise of `cs_n_o` and its next fall, at least QUIET_CYC cycles pass.
- R9: At least ACQ_CYC cycles pass between the start of acquisition and the next fall of `cs_n_o`. Acquisition starts at the ACQ_EDGE-th falling edge, or at the rise of select if the frame is shorter.
- R10: `busy_o` is high from the fall of `cs_n_o` until a new frame may start. It goes low between QUIET_CYC and max(QUIET_CYC, ACQ_CYC) cycles after select rises. Requests while `busy_o` is high start no frame.
- R11: Changes on `mode_i` after a frame is accepted do not affect that frame.
- R12: Every rise of `cs_n_o` comes with exactly one of `valid_o` or `invalid_o`, and neither strobe appears in any other cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Sample request, taken when `busy_o` is low |
| mode_i | input | 2 | Frame kind: 00 full, 01 abandon, 10 sleep, 11 full |
| cs_n_o | output | 1 | Active-low converter select |
| sclk_o | output | 1 | Serial clock, idles high |
| sdata_i | input | 1 | Serial data from the converter |
| data_o | output | RES_W | Last valid result, right-aligned |
| valid_o | output | 1 | One-cycle strobe: `data_o` holds a new result |
| invalid_o | output | 1 | One-cycle strobe: the frame gave no usable result |
| busy_o | output | 1 | Frame running or gap not yet elapsed |
| sleep_o | output | 1 | The converter is asleep after the last frame |

## Verification
The bench builds the block with RES_W = 12, DIV_HALF = 2, a 50 MHz clock, QUIET_NS = 100 and ACQ_NS = 240. These give a 5-cycle quiet gap and a 12-cycle acquisition gap. With these values the quiet gap is the binding limit after a full frame, while the acquisition gap binds after the shorter abandon and sleep frames, so both branches of the hold-off are exercised. ABORT_EDGE = 12 and SLEEP_EDGE = 4 put releases on both sides of the 10-edge threshold. A behavioural converter model counts edges and tracks its own sleep state. Random mode changes and extra requests during frames exercise the latching of the mode and the rejection of requests while busy.

// File: rtl/sadc_pkg.sv
package sadc_pkg;

    // Frame kinds requested on mode_i
    typedef enum logic [1:0] {
        MODE_FULL  = 2'b00,
        MODE_ABORT = 2'b01,
        MODE_SLEEP = 2'b10,
        MODE_SPARE = 2'b11
    } sadc_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LEAD  = 2'd1,
        ST_SHIFT = 2'd2
    } sadc_state_e;

    // Converter protocol constants
    localparam int FRAME_EDGES = 16;  // falling edges of a complete frame
    localparam int AWAKE_EDGES = 10;  // fewer edges than this puts the converter to sleep
    localparam int LAST_RISE   = 15;  // rising edge that carries the least significant bit
    localparam int EDGE_W      = $clog2(FRAME_EDGES + 1);

    typedef logic [EDGE_W-1:0] edge_cnt_t;

    // Outcome of a finished frame
    typedef struct packed {
        logic good;
        logic bad;
        logic asleep;
    } sadc_outcome_t;

    // Nanoseconds to clock cycles, rounded up, never less than one
    function automatic int ns_to_cyc(input int ns, input int mhz);
        int c;
        c = (ns * mhz + 999) / 1000;
        return (c < 1) ? 1 : c;
    endfunction

    // Number of falling edges a frame of the given kind runs for
    function automatic edge_cnt_t edges_for(input sadc_mode_e m, input int abort_e,
                                            input int sleep_e);
        case (m)
            MODE_ABORT: return edge_cnt_t'(abort_e);
            MODE_SLEEP: return edge_cnt_t'(sleep_e);
            default:    return edge_cnt_t'(FRAME_EDGES);
        endcase
    endfunction

    // Decide the frame result from the edge count and the sleep state at acceptance
    function automatic sadc_outcome_t judge(input edge_cnt_t edges, input logic was_asleep);
        sadc_outcome_t o;
        o.good   = (edges == edge_cnt_t'(FRAME_EDGES)) && !was_asleep;
        o.bad    = !o.good;
        o.asleep = (edges < edge_cnt_t'(AWAKE_EDGES));
        return o;
    endfunction

endpackage

// File: rtl/sadc_sclk_gen.sv
module sadc_sclk_gen #(
    parameter int DIV_HALF = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic last,
    output logic sclk_o,
    output logic fall_o,
    output logic rise_o,
    output logic stop_o
);
    localparam int CW = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;

    logic [CW-1:0] cnt_q;
    logic          sclk_q;
    logic          due;

    assign due    = run && (cnt_q == CW'(DIV_HALF - 1));
    assign fall_o = due && sclk_q && !last;
    assign stop_o = due && sclk_q && last;
    assign rise_o = due && !sclk_q;
    assign sclk_o = sclk_q;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt_q  <= '0;
            sclk_q <= 1'b1;
        end else if (due) begin
            cnt_q <= '0;
            if (!stop_o) begin
                sclk_q <= ~sclk_q;
            end
        end else begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

    // R2: the clock parks high as soon as the burst is not running
    p_sclk_park_r2: assert property (@(posedge clk) disable iff (rst)
        !run |=> sclk_o);

    // R3: a stopped burst never produces an extra falling edge
    p_stop_no_fall_r3: assert property (@(posedge clk) disable iff (rst)
        stop_o |=> sclk_o);

endmodule

// File: rtl/sadc_rx_shift.sv
module sadc_rx_shift #(
    parameter int RES_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             shift_en,
    input  logic             bit_i,
    output logic [RES_W-1:0] word_o
);
    logic [RES_W-1:0] sr_q;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            sr_q <= '0;
        end else if (shift_en) begin
            sr_q <= {sr_q[RES_W-2:0], bit_i};
        end
    end

    assign word_o = sr_q;

    // R4: the register only moves when a bit is taken
    p_hold_no_shift_r4: assert property (@(posedge clk) disable iff (rst)
        (!shift_en && !clear) |=> $stable(word_o));

endmodule

// File: rtl/sadc_gap_timer.sv
module sadc_gap_timer #(
    parameter int QUIET_CYC = 2,
    parameter int ACQ_CYC   = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic frame_end,
    input  logic acq_start,
    output logic ready_o
);
    localparam int GMAX = (QUIET_CYC > ACQ_CYC) ? QUIET_CYC : ACQ_CYC;
    localparam int GW   = $clog2(GMAX + 1);

    logic [GW-1:0] quiet_q;
    logic [GW-1:0] acq_q;
    logic          quiet_done;
    logic          acq_done;

    assign quiet_done = (quiet_q == GW'(QUIET_CYC));
    assign acq_done   = (acq_q == GW'(ACQ_CYC));
    assign ready_o    = quiet_done && acq_done;

    always_ff @(posedge clk) begin
        if (rst) begin
            quiet_q <= GW'(QUIET_CYC);
        end else if (frame_end) begin
            quiet_q <= '0;
        end else if (!quiet_done) begin
            quiet_q <= quiet_q + GW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acq_q <= GW'(ACQ_CYC);
        end else if (acq_start) begin
            acq_q <= '0;
        end else if (!acq_done) begin
            acq_q <= acq_q + GW'(1);
        end
    end

    // R8: the end of a frame always closes the gap for the next cycle
    p_gap_closed_r8: assert property (@(posedge clk) disable iff (rst)
        frame_end |=> !ready_o);

    // R9: a fresh acquisition start always closes the gap
    p_acq_closed_r9: assert property (@(posedge clk) disable iff (rst)
        acq_start |=> !ready_o);

endmodule

// File: rtl/sadc_ctrl.sv
module sadc_ctrl
    import sadc_pkg::*;
#(
    parameter int RES_W      = 12,
    parameter int DIV_HALF   = 2,
    parameter int CLK_MHZ    = 50,
    parameter int LEAD_NS    = 10,
    parameter int QUIET_NS   = 25,
    parameter int ACQ_NS     = 200,
    parameter int ABORT_EDGE = 12,
    parameter int SLEEP_EDGE = 4,
    parameter int ACQ_EDGE   = 14
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic [1:0]       mode_i,
    output logic             cs_n_o,
    output logic             sclk_o,
    input  logic             sdata_i,
    output logic [RES_W-1:0] data_o,
    output logic             valid_o,
    output logic             invalid_o,
    output logic             busy_o,
    output logic             sleep_o
);
    localparam int LEAD_CYC  = ns_to_cyc(LEAD_NS, CLK_MHZ);
    localparam int QUIET_CYC = ns_to_cyc(QUIET_NS, CLK_MHZ);
    localparam int ACQ_CYC   = ns_to_cyc(ACQ_NS, CLK_MHZ);
    localparam int LW        = $clog2(LEAD_CYC + 1);

    sadc_state_e      state_q;
    logic [LW-1:0]    lead_q;
    edge_cnt_t        falls_q;
    edge_cnt_t        rises_q;
    edge_cnt_t        target_q;
    logic             was_asleep_q;
    logic             cs_n_q;
    logic             valid_q;
    logic             invalid_q;
    logic             sleep_q;
    logic [RES_W-1:0] data_q;

    logic             gap_ready;
    logic             accept;
    logic             run;
    logic             last;
    logic             fall_tick;
    logic             rise_tick;
    logic             stop_tick;
    logic             shift_en;
    logic             acq_start;
    logic [RES_W-1:0] word;
    sadc_outcome_t    outcome;

    assign run      = (state_q == ST_SHIFT);
    assign last     = (falls_q == target_q);
    assign accept   = (state_q == ST_IDLE) && gap_ready && start_i;
    assign shift_en = rise_tick && (rises_q < edge_cnt_t'(LAST_RISE));
    assign acq_start = (fall_tick && (falls_q == edge_cnt_t'(ACQ_EDGE - 1)))
                    || (stop_tick && (falls_q < edge_cnt_t'(ACQ_EDGE)));
    assign outcome  = judge(falls_q, was_asleep_q);

    sadc_sclk_gen #(
        .DIV_HALF (DIV_HALF)
    ) u_sclk (
        .clk    (clk),
        .rst    (rst),
        .run    (run),
        .last   (last),
        .sclk_o (sclk_o),
        .fall_o (fall_tick),
        .rise_o (rise_tick),
        .stop_o (stop_tick)
    );

    sadc_rx_shift #(
        .RES_W (RES_W)
    ) u_rx (
        .clk      (clk),
        .rst      (rst),
        .clear    (accept),
        .shift_en (shift_en),
        .bit_i    (sdata_i),
        .word_o   (word)
    );

    sadc_gap_timer #(
        .QUIET_CYC (QUIET_CYC),
        .ACQ_CYC   (ACQ_CYC)
    ) u_gap (
        .clk       (clk),
        .rst       (rst),
        .frame_end (stop_tick),
        .acq_start (acq_start),
        .ready_o   (gap_ready)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q      <= ST_IDLE;
            lead_q       <= '0;
            falls_q      <= '0;
            rises_q      <= '0;
            target_q     <= edge_cnt_t'(FRAME_EDGES);
            was_asleep_q <= 1'b0;
            cs_n_q       <= 1'b1;
            valid_q      <= 1'b0;
            invalid_q    <= 1'b0;
            sleep_q      <= 1'b0;
            data_q       <= '0;
        end else begin
            valid_q   <= 1'b0;
            invalid_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        cs_n_q       <= 1'b0;
                        target_q     <= edges_for(sadc_mode_e'(mode_i), ABORT_EDGE, SLEEP_EDGE);
                        was_asleep_q <= sleep_q;
                        falls_q      <= '0;
                        rises_q      <= '0;
                        lead_q       <= '0;
                        state_q      <= ST_LEAD;
                    end
                end
                ST_LEAD: begin
                    if (lead_q == LW'(LEAD_CYC - 1)) begin
                        state_q <= ST_SHIFT;
                    end else begin
                        lead_q <= lead_q + LW'(1);
                    end
                end
                ST_SHIFT: begin
                    if (fall_tick) begin
                        falls_q <= falls_q + edge_cnt_t'(1);
                    end
                    if (rise_tick) begin
                        rises_q <= rises_q + edge_cnt_t'(1);
                    end
                    if (stop_tick) begin
                        cs_n_q    <= 1'b1;
                        state_q   <= ST_IDLE;
                        valid_q   <= outcome.good;
                        invalid_q <= outcome.bad;
                        sleep_q   <= outcome.asleep;
                        if (outcome.good) begin
                            data_q <= word;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign cs_n_o    = cs_n_q;
    assign valid_o   = valid_q;
    assign invalid_o = invalid_q;
    assign sleep_o   = sleep_q;
    assign data_o    = data_q;
    assign busy_o    = !((state_q == ST_IDLE) && gap_ready);

    // R2: the serial clock never leaves its idle level while select is high
    p_sclk_idle_r2: assert property (@(posedge clk) disable iff (rst)
        cs_n_o |-> sclk_o);

    // R3: the falling-edge count never passes the frame length that was latched
    p_edge_bound_r3: assert property (@(posedge clk) disable iff (rst)
        falls_q <= target_q);

    // R5: the result only changes together with a valid strobe
    p_data_hold_r5: assert property (@(posedge clk) disable iff (rst)
        !valid_o |-> $stable(data_o));

    // R6: the sleep flag moves only when select is released
    p_sleep_moves_r6: assert property (@(posedge clk) disable iff (rst)
        !$stable(sleep_o) |-> $rose(cs_n_o));

    // R7: a frame accepted asleep ends without a valid strobe
    p_no_valid_asleep_r7: assert property (@(posedge clk) disable iff (rst)
        (stop_tick && was_asleep_q) |=> !valid_o);

    // R10: busy covers the whole time select is low
    p_busy_frame_r10: assert property (@(posedge clk) disable iff (rst)
        !cs_n_o |-> busy_o);

    // R10: select only falls after a cycle in which busy was low
    p_fall_gated_r10: assert property (@(posedge clk) disable iff (rst)
        $fell(cs_n_o) |-> !$past(busy_o));

    // R11: the latched frame length holds for the whole frame
    p_target_held_r11: assert property (@(posedge clk) disable iff (rst)
        (!cs_n_o && !$fell(cs_n_o)) |-> $stable(target_q));

    // R12: each release carries exactly one strobe
    p_one_strobe_r12: assert property (@(posedge clk) disable iff (rst)
        $rose(cs_n_o) |-> ($countones({valid_o, invalid_o}) == 1));

    // R12: strobes appear only at a release
    p_strobe_at_release_r12: assert property (@(posedge clk) disable iff (rst)
        (valid_o || invalid_o) |-> $rose(cs_n_o));

endmodule

// File: tb/sadc_ctrl_bench.sv
module sadc_ctrl_bench;
    localparam int RES_W      = 12;
    localparam int DIV_HALF   = 2;
    localparam int CLK_MHZ    = 50;
    localparam int LEAD_NS    = 10;
    localparam int QUIET_NS   = 100;
    localparam int ACQ_NS     = 240;
    localparam int ABORT_EDGE = 12;
    localparam int SLEEP_EDGE = 4;
    localparam int ACQ_EDGE   = 14;

    // Bench-side timing derived from the requirements
    localparam int L_CYC = ((LEAD_NS * CLK_MHZ + 999) / 1000 < 1) ? 1 : (LEAD_NS * CLK_MHZ + 999) / 1000;
    localparam int Q_CYC = (QUIET_NS * CLK_MHZ + 999) / 1000;
    localparam int A_CYC = (ACQ_NS * CLK_MHZ + 999) / 1000;
    localparam int GAP_MAX = (Q_CYC > A_CYC) ? Q_CYC : A_CYC;
    localparam int FIRST_BIT = 15 - RES_W + 1;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             start = 1'b0;
    logic [1:0]       mode = 2'b00;
    logic             cs_n;
    logic             sclk;
    wire              sdata;
    logic [RES_W-1:0] data;
    logic             valid;
    logic             invalid;
    logic             busy;
    logic             sleep;

    sadc_ctrl #(
        .RES_W (RES_W), .DIV_HALF (DIV_HALF), .CLK_MHZ (CLK_MHZ), .LEAD_NS (LEAD_NS),
        .QUIET_NS (QUIET_NS), .ACQ_NS (ACQ_NS), .ABORT_EDGE (ABORT_EDGE),
        .SLEEP_EDGE (SLEEP_EDGE), .ACQ_EDGE (ACQ_EDGE)
    ) u_sadc_ctrl (
        .clk (clk), .rst (rst), .start_i (start), .mode_i (mode),
        .cs_n_o (cs_n), .sclk_o (sclk), .sdata_i (sdata), .data_o (data),
        .valid_o (valid), .invalid_o (invalid), .busy_o (busy), .sleep_o (sleep)
    );

    always #10 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int  n_chk = 0;
    int  n_err = 0;
    bit  done = 1'b0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    function automatic int exp_edges(input logic [1:0] m);
        case (m)
            2'b01:   return ABORT_EDGE;
            2'b10:   return SLEEP_EDGE;
            default: return 16;
        endcase
    endfunction

    // ---------------- behavioural converter ----------------
    logic [RES_W-1:0] m_sample = '0;
    logic             m_asleep = 1'b0;
    logic             m_drive  = 1'b0;
    logic             m_bit    = 1'b0;
    bit               m_in     = 1'b0;
    int               m_falls  = 0;

    assign sdata = m_drive ? m_bit : 1'bz;

    function automatic logic bit_for(input int k, input logic [RES_W-1:0] s);
        if (k >= FIRST_BIT && k <= 15) return s[15 - k];
        return 1'b0;
    endfunction

    always @(negedge cs_n) begin
        m_in = 1'b1; m_falls = 0; m_drive = 1'b1; m_bit = 1'b0;
    end
    always @(negedge sclk) begin
        if (m_in) begin
            m_falls++;
            m_bit = bit_for(m_falls, m_sample);
        end
    end
    always @(posedge cs_n) begin
        if (m_in) begin
            m_in = 1'b0;
            m_drive = 1'b0;
            m_asleep = (m_falls < 10);
        end
    end

    // ---------------- monitor ----------------
    logic [1:0]       acc_mode = 2'b00;
    int               frames_req = 0;
    int               frames_seen = 0;
    logic             prev_cs = 1'b1;
    logic             prev_sclk = 1'b1;
    int               t_csfall = 0, t_csrise = 0, t_lastfall = 0, t_lastrise = 0, t_acq = 0;
    int               falls = 0;
    bit               have_prev = 1'b0;
    bit               wait_busy = 1'b0;
    logic [1:0]       f_mode = 2'b00;
    logic [RES_W-1:0] f_sample = '0;
    logic             f_asleep = 1'b0;
    logic [RES_W-1:0] last_data = '0;
    int               n_valid = 0, n_invalid = 0, n_wake = 0, n_sleep_enter = 0;

    always @(negedge clk) begin
        if (!rst && !done) begin
            if (prev_cs && !cs_n) begin
                frames_seen++;
                falls = 0;
                t_csfall = cyc;
                f_mode = acc_mode;
                f_sample = m_sample;
                f_asleep = m_asleep;
                if (have_prev) begin
                    check(cyc - t_csrise >= Q_CYC, "R8 quiet gap", cyc - t_csrise, Q_CYC);
                    check(cyc - t_acq >= A_CYC, "R9 acquisition gap", cyc - t_acq, A_CYC);
                end
            end
            if (!cs_n && prev_sclk && !sclk) begin
                falls++;
                if (falls == 1)
                    check(cyc - t_csfall == L_CYC + DIV_HALF, "R2 lead time", cyc - t_csfall, L_CYC + DIV_HALF);
                else
                    check(cyc - t_lastfall == 2 * DIV_HALF, "R2 serial period", cyc - t_lastfall, 2 * DIV_HALF);
                t_lastfall = cyc;
                if (falls == ACQ_EDGE) t_acq = cyc;
            end
            if (!cs_n && !prev_sclk && sclk) t_lastrise = cyc;
            if (cs_n && !sclk) check(1'b0, "R2 clock idle high", 0, 1);

            if (!prev_cs && cs_n) begin
                int  ee;
                bit  good;
                ee = exp_edges(f_mode);
                good = (falls == 16) && !f_asleep;
                check(falls == ee, (f_mode == 2'b01) ? "R5 abandon edge count" :
                      (f_mode == 2'b10) ? "R6 sleep edge count" : "R3 full edge count", falls, ee);
                check(cyc - t_lastrise == DIV_HALF, "R3 release after last rise", cyc - t_lastrise, DIV_HALF);
                check(valid == good, "R12 valid strobe at release", valid, good);
                check(invalid == !good, "R12 invalid strobe at release", invalid, !good);
                if (good) begin
                    check(data == f_sample, "R4 captured result", data, f_sample);
                    last_data = f_sample;
                    n_valid++;
                end else begin
                    check(data == last_data, "R5 result held on bad frame", data, last_data);
                    n_invalid++;
                    if (f_asleep) check(!valid, "R7 no valid while asleep", valid, 0);
                end
                check(sleep == (falls < 10), "R6 sleep flag after frame", sleep, falls < 10);
                check(sleep == m_asleep, "R7 sleep matches converter", sleep, m_asleep);
                if (f_asleep && falls >= 10) n_wake++;
                if (!f_asleep && falls < 10) n_sleep_enter++;
                if (falls < ACQ_EDGE) t_acq = cyc;
                t_csrise = cyc;
                have_prev = 1'b1;
                wait_busy = 1'b1;
            end else if (valid || invalid) begin
                check(1'b0, "R12 strobe outside release", 1, 0);
            end

            if (!cs_n && !busy) check(1'b0, "R10 busy during frame", 0, 1);
            if (wait_busy && !busy) begin
                check(cyc - t_csrise >= Q_CYC && cyc - t_csrise <= GAP_MAX,
                      "R10 busy release window", cyc - t_csrise, GAP_MAX);
                wait_busy = 1'b0;
            end
            prev_cs = cs_n;
            prev_sclk = sclk;
        end
    end

    // ---------------- stimulus ----------------
    task automatic run_frame(input logic [1:0] m, input logic [RES_W-1:0] s, input bit noise);
        @(negedge clk);
        while (busy) @(negedge clk);
        m_sample = s;
        acc_mode = m;
        mode = m;
        start = 1'b1;
        frames_req++;
        @(negedge clk);
        start = 1'b0;
        check(cs_n == 1'b0, "R2 select falls after request", cs_n, 0);
        while (busy) begin
            if (noise) begin
                mode = 2'($urandom);                       // R11: ignored mid-frame
                start = ($urandom % 3 == 0);               // R10: ignored while busy
            end
            @(negedge clk);
            start = 1'b0;
        end
        start = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
        finish_run();
    end

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'h5AD0_C0DE);
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: outputs during reset
        check(cs_n == 1'b1 && sclk == 1'b1, "R1 lines idle in reset", {cs_n, sclk}, 3);
        rst = 1'b0;
        @(negedge clk);
        check(cs_n == 1'b1 && sclk == 1'b1, "R1 lines idle after reset", {cs_n, sclk}, 3);
        check(!busy && !valid && !invalid && !sleep, "R1 status after reset",
              {busy, valid, invalid, sleep}, 0);

        // Directed corner cases
        run_frame(2'b00, 12'hA5C, 1'b0);   // R4 full read
        run_frame(2'b00, 12'h000, 1'b0);   // R4 all zeros
        run_frame(2'b00, 12'hFFF, 1'b1);   // R4 all ones, noise on mode/start
        run_frame(2'b01, 12'h321, 1'b0);   // R5 abandon
        run_frame(2'b00, 12'h555, 1'b0);   // R4 still powered
        run_frame(2'b10, 12'h0F0, 1'b0);   // R6 enter sleep
        run_frame(2'b00, 12'h123, 1'b0);   // R7 wake frame, no result
        run_frame(2'b00, 12'h3C3, 1'b0);   // R4 valid again
        run_frame(2'b10, 12'h111, 1'b0);   // R6 sleep
        run_frame(2'b10, 12'h222, 1'b0);   // R7 stays asleep
        run_frame(2'b01, 12'h444, 1'b0);   // R7 abandon wakes
        run_frame(2'b11, 12'h9A6, 1'b0);   // R3 spare code reads fully

        // Random frames with mid-frame disturbance
        for (int i = 0; i < 60; i++) begin
            run_frame(2'($urandom), RES_W'($urandom), 1'b1);
        end

        repeat (20) @(negedge clk);
        check(frames_seen == frames_req, "R10 no extra frames from ignored requests",
              frames_seen, frames_req);
        check(n_wake > 0 && n_sleep_enter > 0, "R7 sleep entry and wake both seen",
              n_wake, 1);
        check(n_valid > 0 && n_invalid > 0, "R12 both outcomes seen", n_valid, 1);
        finish_run();
    end

endmodule